// File: doc/BRIEF.md
# Slave Address Match and Wake-Up Filter

This block sits behind the byte receiver of a serial bus port. It decides whether an incoming address byte selects this device, and it controls the interrupt raised toward the processor. Software loads the device's own 8-bit address into a holding register through a write strobe. The receiver then presents each completed byte with a valid strobe and a flag that marks the byte as an address. A separate strobe reports a stop condition on the bus.

When an address byte arrives, the block compares it with the stored address and updates a selected flag and a bus-released flag. The comparison can be told to ignore the least significant bit. A wake-up mode on the two-wire I2C-style bus keeps the processor asleep through traffic meant for other devices. In that mode only an own-address hit or a stop condition raises the interrupt. In the three-wire mode no addressing exists, so the selected flag stays low and the wake-up filter has no effect.

Top module: `slave_addr_match`

## Requirements
- R1: A write strobe loads the 8-bit own address. The new value is used for every compare from the following cycle on. The register is not reset, so its value after reset is undefined.
- R2: In bus mode 1 (two-wire, code 2'b01) or mode 2 (I2C-style, code 2'b10), an address byte (byte_valid=1, byte_is_addr=1) equal to the own address sets match_flag to 1 in the cycle after the strobe.
- R3: When lsb_mask is 1, bit 0 is left out of the compare and only bits 7..1 must be equal. When lsb_mask is 0, a difference in bit 0 alone is a mismatch.
- R4: In modes 1 and 2, an address byte that does not match clears both match_flag and release_flag in the cycle after the strobe. A matching address byte leaves release_flag unchanged.
- R5: A stop strobe clears match_flag and sets release_flag in the cycle after it. When a stop and an address byte arrive in the same cycle, the stop wins.
- R6: Outside wake-up filtering, every byte strobe or stop strobe gives irq high for exactly the next cycle, whether or not the address matched.
- R7: With wake_en=1 in mode 2, irq pulses only for a matching address byte or a stop. Data bytes and mismatching address bytes raise no interrupt.
- R8: In mode 0 (three-wire, code 2'b00), match_flag is held at 0, an address byte leaves release_flag unchanged, and wake_en is ignored. wake_en is also ignored in mode 1.
- R9: After reset, match_flag, release_flag and irq are all 0.
- R10: A data byte (byte_is_addr=0) changes neither match_flag nor release_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_wr_en | input | 1 | Load strobe for the own address |
| addr_wr_data | input | 8 | Own address value to load |
| lsb_mask | input | 1 | Leave bit 0 out of the compare |
| wake_en | input | 1 | Wake-up interrupt filtering enable |
| bus_mode | input | 2 | 0 three-wire, 1 two-wire, 2 I2C-style, 3 treated as two-wire |
| byte_valid | input | 1 | A received byte is complete this cycle |
| byte_is_addr | input | 1 | The completed byte is an address byte |
| rx_byte | input | 8 | Received byte, sampled with byte_valid |
| stop_det | input | 1 | Stop condition seen this cycle |
| match_flag | output | 1 | Device is selected by the last address |
| release_flag | output | 1 | Bus released status |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The checker watches several properties on every cycle. It checks that a stop always clears the selected flag and sets the released flag, and that the three-wire mode never shows a selection. It checks that a rise of the selected flag only ever follows an address strobe. It checks that an interrupt only follows a byte or stop strobe, that filtered data bytes give no interrupt, and that unfiltered strobes always give one. Only the bench's scenarios can show the value side of the design. Those scenarios cover equality against the stored address, the effect of the LSB mask, the use of a rewritten address, and the exact combinations of flag states that a walked sequence produces.

// File: rtl/sam_pkg.sv
package sam_pkg;
  typedef enum logic [1:0] {
    BUS_3WIRE = 2'b00,
    BUS_2WIRE = 2'b01,
    BUS_I2C   = 2'b10,
    BUS_RSVD  = 2'b11
  } bus_mode_e;
endpackage

// File: rtl/sam_addr_reg.sv
module sam_addr_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (wr_en) q_nxt = wr_data;
  end

  // data register: deliberately not reset
  always_ff @(posedge clk) begin
    q <= q_nxt;
  end
endmodule

// File: rtl/sam_addr_cmp.sv
module sam_addr_cmp #(
  parameter int W         = 8,
  parameter int MASK_BITS = 1
) (
  input  logic [W-1:0] own_addr,
  input  logic [W-1:0] rx_addr,
  input  logic         mask_en,
  output logic         hit
);
  logic [W-1:0] care;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_care
      if (i < MASK_BITS) begin : g_maskable
        assign care[i] = ~mask_en;
      end else begin : g_fixed
        assign care[i] = 1'b1;
      end
    end
  endgenerate

  assign hit = ((own_addr ^ rx_addr) & care) == '0;
endmodule

// File: rtl/sam_flags.sv
module sam_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_evt,
  input  logic hit,
  input  logic stop,
  input  logic cmp_active,
  output logic match_q,
  output logic release_q
);
  logic match_d, release_d;

  always_comb begin
    match_d   = match_q;
    release_d = release_q;
    if (stop) begin
      match_d   = 1'b0;
      release_d = 1'b1;
    end else if (addr_evt && cmp_active) begin
      match_d = hit;
      if (!hit) release_d = 1'b0;
    end
    if (!cmp_active) match_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q   <= 1'b0;
      release_q <= 1'b0;
    end else begin
      match_q   <= match_d;
      release_q <= release_d;
    end
  end
endmodule

// File: rtl/sam_irq.sv
module sam_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic byte_valid,
  input  logic addr_evt,
  input  logic hit,
  input  logic stop,
  input  logic wake_active,
  output logic irq_q
);
  logic irq_d;

  always_comb begin
    if (wake_active) irq_d = stop | (addr_evt & hit);
    else             irq_d = stop | byte_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/slave_addr_match.sv
module slave_addr_match #(
  parameter int ADDR_W    = 8,
  parameter int MASK_BITS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_wr_en,
  input  logic [ADDR_W-1:0] addr_wr_data,
  input  logic              lsb_mask,
  input  logic              wake_en,
  input  logic [1:0]        bus_mode,
  input  logic              byte_valid,
  input  logic              byte_is_addr,
  input  logic [ADDR_W-1:0] rx_byte,
  input  logic              stop_det,
  output logic              match_flag,
  output logic              release_flag,
  output logic              irq
);
  import sam_pkg::*;

  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic [ADDR_W-1:0] own_addr;
  logic              hit, addr_evt, cmp_active, wake_active;
  bus_mode_e         mode;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign mode        = bus_mode_e'(bus_mode);
  assign cmp_active  = (mode != BUS_3WIRE);
  assign wake_active = wake_en && (mode == BUS_I2C);
  assign addr_evt    = byte_valid && byte_is_addr && cmp_active;

  sam_addr_reg #(.W(ADDR_W)) u_reg (
    .clk(clk), .wr_en(addr_wr_en), .wr_data(addr_wr_data), .q(own_addr)
  );

  sam_addr_cmp #(.W(ADDR_W), .MASK_BITS(MASK_BITS)) u_cmp (
    .own_addr(own_addr), .rx_addr(rx_byte), .mask_en(lsb_mask), .hit(hit)
  );

  sam_flags u_flags (
    .clk(clk), .rst_n(rst_int_n), .addr_evt(addr_evt), .hit(hit),
    .stop(stop_det), .cmp_active(cmp_active),
    .match_q(match_flag), .release_q(release_flag)
  );

  sam_irq u_irq (
    .clk(clk), .rst_n(rst_int_n), .byte_valid(byte_valid), .addr_evt(addr_evt),
    .hit(hit), .stop(stop_det), .wake_active(wake_active), .irq_q(irq)
  );
endmodule

// File: rtl/slave_addr_match_chk.sv
module slave_addr_match_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wake_en,
  input logic [1:0] bus_mode,
  input logic       byte_valid,
  input logic       byte_is_addr,
  input logic       stop_det,
  input logic       match_flag,
  input logic       release_flag,
  input logic       irq
);
  p_stop_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!match_flag && release_flag));

  p_three_wire_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_mode == 2'b00) |=> !match_flag);

  p_match_needs_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_flag) |-> $past(byte_valid && byte_is_addr));

  p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(byte_valid || stop_det));

  p_wake_data_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_en && bus_mode == 2'b10 && byte_valid && !byte_is_addr && !stop_det) |=> !irq);

  p_plain_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !(wake_en && bus_mode == 2'b10)) |=> irq);

  p_data_keeps_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !byte_is_addr && !stop_det && bus_mode != 2'b00)
      |=> ($stable(match_flag) && $stable(release_flag)));
endmodule

bind slave_addr_match slave_addr_match_chk u_chk (
  .clk(clk), .rst_n(rst_int_n), .wake_en(wake_en), .bus_mode(bus_mode),
  .byte_valid(byte_valid), .byte_is_addr(byte_is_addr), .stop_det(stop_det),
  .match_flag(match_flag), .release_flag(release_flag), .irq(irq)
);

// File: tb/slave_addr_match_test.sv
module slave_addr_match_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       addr_wr_en, lsb_mask, wake_en, byte_valid, byte_is_addr, stop_det;
  logic [7:0] addr_wr_data, rx_byte;
  logic [1:0] bus_mode;
  logic       match_flag, release_flag, irq;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  slave_addr_match uut (
    .clk(clk), .rst_n(rst_n), .addr_wr_en(addr_wr_en), .addr_wr_data(addr_wr_data),
    .lsb_mask(lsb_mask), .wake_en(wake_en), .bus_mode(bus_mode),
    .byte_valid(byte_valid), .byte_is_addr(byte_is_addr), .rx_byte(rx_byte),
    .stop_det(stop_det), .match_flag(match_flag), .release_flag(release_flag), .irq(irq)
  );

  // {mode[1:0], mask, wake, valid, is_addr, stop, rx[7:0], exp_match, exp_rel, exp_irq}
  localparam int NV = 17;
  localparam logic [17:0] VEC [NV] = '{
    {2'd1,1'b0,1'b0,1'b1,1'b1,1'b0,8'hA4,1'b1,1'b0,1'b1}, // R2 exact hit
    {2'd1,1'b0,1'b0,1'b1,1'b1,1'b0,8'hA5,1'b0,1'b0,1'b1}, // R3 lsb differs, unmasked
    {2'd1,1'b1,1'b0,1'b1,1'b1,1'b0,8'hA5,1'b1,1'b0,1'b1}, // R3 masked hit
    {2'd1,1'b0,1'b0,1'b0,1'b0,1'b1,8'h00,1'b0,1'b1,1'b1}, // R5 stop
    {2'd1,1'b0,1'b0,1'b1,1'b0,1'b0,8'h33,1'b0,1'b1,1'b1}, // R10 data byte
    {2'd1,1'b0,1'b0,1'b1,1'b1,1'b0,8'hA4,1'b1,1'b1,1'b1}, // R4 hit keeps release
    {2'd1,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,1'b1,1'b1,1'b1}, // R10 data keeps match
    {2'd1,1'b0,1'b0,1'b1,1'b1,1'b0,8'h10,1'b0,1'b0,1'b1}, // R4 mismatch clears
    {2'd2,1'b0,1'b1,1'b1,1'b0,1'b0,8'h55,1'b0,1'b0,1'b0}, // R7 data filtered
    {2'd2,1'b0,1'b1,1'b1,1'b1,1'b0,8'h12,1'b0,1'b0,1'b0}, // R7 miss filtered
    {2'd2,1'b0,1'b1,1'b1,1'b1,1'b0,8'hA4,1'b1,1'b0,1'b1}, // R7 hit wakes
    {2'd2,1'b0,1'b1,1'b0,1'b0,1'b1,8'h00,1'b0,1'b1,1'b1}, // R7 stop wakes
    {2'd0,1'b0,1'b1,1'b1,1'b1,1'b0,8'hA4,1'b0,1'b1,1'b1}, // R8 three-wire no match
    {2'd0,1'b0,1'b0,1'b1,1'b1,1'b0,8'h00,1'b0,1'b1,1'b1}, // R8 release untouched
    {2'd2,1'b0,1'b1,1'b1,1'b1,1'b1,8'hA4,1'b0,1'b1,1'b1}, // R5 stop wins over hit
    {2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,8'h77,1'b0,1'b1,1'b1}, // R8 wake ignored in mode 1
    {2'd2,1'b1,1'b1,1'b1,1'b1,1'b0,8'hA5,1'b1,1'b1,1'b1}  // R3 R7 masked hit wakes
  };

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic idle();
    addr_wr_en = 0; byte_valid = 0; byte_is_addr = 0; stop_det = 0;
  endtask

  task automatic apply(input logic [17:0] v, input string req);
    @(negedge clk);
    bus_mode = v[17:16]; lsb_mask = v[15]; wake_en = v[14];
    byte_valid = v[13]; byte_is_addr = v[12]; stop_det = v[11]; rx_byte = v[10:3];
    @(negedge clk);
    idle();
    check(req, match_flag,   v[2], "match_flag");
    check(req, release_flag, v[1], "release_flag");
    check(req, irq,          v[0], "irq");
    @(negedge clk);
    check(req, irq, 1'b0, "irq pulse width");
  endtask

  task automatic write_addr(input logic [7:0] a);
    @(negedge clk);
    addr_wr_en = 1; addr_wr_data = a;
    @(negedge clk);
    addr_wr_en = 0;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    addr_wr_data = 0; lsb_mask = 0; wake_en = 0; bus_mode = 2'd1; rx_byte = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R9", match_flag, 1'b0, "match after reset");
    check("R9", release_flag, 1'b0, "release after reset");
    check("R9", irq, 1'b0, "irq after reset");
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R9", irq, 1'b0, "irq after release");

    write_addr(8'hA4); // R1
    for (int i = 0; i < NV; i++) apply(VEC[i], $sformatf("vec%0d", i));

    // R1: rewritten address takes effect, old one no longer matches
    write_addr(8'h3C);
    apply({2'd1,1'b0,1'b0,1'b1,1'b1,1'b0,8'h3C,1'b1,1'b1,1'b1}, "R1 new addr");
    apply({2'd1,1'b0,1'b0,1'b1,1'b1,1'b0,8'hA4,1'b0,1'b0,1'b1}, "R1 old addr");
    // R1: write and compare back to back
    @(negedge clk);
    addr_wr_en = 1; addr_wr_data = 8'h42;
    @(negedge clk);
    addr_wr_en = 0; bus_mode = 2'd2; wake_en = 0; lsb_mask = 0;
    byte_valid = 1; byte_is_addr = 1; rx_byte = 8'h42;
    @(negedge clk);
    idle();
    check("R1", match_flag, 1'b1, "match on next-cycle compare");
    // R6: consecutive bytes give consecutive pulses
    @(negedge clk);
    bus_mode = 2'd1; byte_valid = 1; rx_byte = 8'h01;
    @(negedge clk);
    check("R6", irq, 1'b1, "first back-to-back irq");
    @(negedge clk);
    idle();
    check("R6", irq, 1'b1, "second back-to-back irq");
    @(negedge clk);
    check("R6", irq, 1'b0, "irq drops");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule